// File: doc/BRIEF.md
# Receive FIFO with Fill-Level Interrupt

This block sits behind a serial receiver. Each completed character arrives with a one-cycle write strobe and is stored in a first-in, first-out buffer of up to 64 entries. The host takes characters from the head with a read strobe. The oldest stored character is always visible on the read data port.

From the fill level, the block derives three host-facing signals:

- A data-ready flag that is set whenever the buffer holds anything.
- A receive-data-available interrupt that is raised while the fill level is at or above a selectable threshold.
- A 4-bit interrupt identification code that reports that interrupt.

The interrupt needs no acknowledge. It follows the fill level directly, so draining the buffer below the threshold withdraws it.

When buffering is switched off, the block acts as a single holding slot and interrupts on every character. A write that finds no room is discarded and latches an overrun flag until the host performs a status read.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset, the fill level is 0, data-ready is 0, the interrupt is 0, the identification code is 4'b0001 and the overrun flag is 0.
- R2: Data-ready becomes 1 on the clock edge that stores a character into an empty buffer. It stays 1 while the fill level is non-zero and returns to 0 on the edge that removes the last character.
- R3: Characters leave in the order they were stored. The read data port shows the oldest stored character, and a read strobe on a non-empty buffer removes it. With buffering on, the capacity is 64 characters.
- R4: With buffering on and the interrupt enabled, the interrupt is 1 exactly when the fill level is at or above the threshold. The 2-bit select picks the threshold: 0 gives 8, 1 gives 16, 2 gives 56 and 3 gives 60. A change of select takes effect at once.
- R5: The interrupt falls in the same cycle that the fill level drops below the threshold. No acknowledge or status read is needed.
- R6: The identification code is 4'b0100 while the interrupt is 1 and 4'b0001 otherwise. Bit 0 set means "nothing pending", and the two always change together.
- R7: With the interrupt enable at 0, the interrupt stays 0 and the code stays 4'b0001, while data-ready and the fill level keep tracking the buffer.
- R8: With buffering off, capacity is one character and the threshold is one character. The interrupt, when enabled, is 1 whenever a character is held.
- R9: A write that finds the buffer at capacity, with no read in the same cycle, is discarded. The fill level is unchanged and the overrun flag is set. A status read clears the flag, and a new overrun in the same cycle as a status read wins.
- R10: A write and a read in the same cycle on a non-empty buffer leave the fill level unchanged, even at capacity, and do not set overrun. A read strobe on an empty buffer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: buffered mode, 0: single holding slot |
| rx_irq_en | input | 1 | Receive interrupt enable |
| trig_sel | input | 2 | Threshold select (8/16/56/60) |
| wr_stb | input | 1 | Character-complete strobe from the shift register |
| wr_data | input | 8 | Character to store |
| rd_stb | input | 1 | Host read strobe, pops the head |
| stat_rd | input | 1 | Host status read, clears overrun |
| rd_data | output | 8 | Oldest stored character |
| fill_level | output | 7 | Number of stored characters |
| data_ready | output | 1 | Buffer non-empty |
| rx_irq | output | 1 | Receive-data-available interrupt |
| isr_code | output | 4 | Interrupt identification code |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Every host-facing flag is a function of one stored count, so a corrupted count shows up at once. On the next sampled cycle the fill level disagrees with the bench model, and the interrupt or data-ready flag is off at the threshold or empty boundaries. A broken pointer or storage slot is only visible later: it appears when the affected character reaches the head, which the scoreboard catches on that read. Overrun and simultaneous-access faults show up as a fill level or flag mismatch on the cycle right after the offending write.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   localparam logic [3:0] ISR_NONE    = 4'b0001;
   localparam logic [3:0] ISR_RX_AVAIL = 4'b0100;

   typedef enum logic [1:0] {
      TRIG_SEL_0 = 2'd0,
      TRIG_SEL_1 = 2'd1,
      TRIG_SEL_2 = 2'd2,
      TRIG_SEL_3 = 2'd3
   } trig_sel_e;

   typedef struct packed {
      logic push;
      logic pop;
      logic drop;
   } flow_t;

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned WIDTH = 8,
   localparam int unsigned PW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_data,
   output logic [CW-1:0]    level
);

   logic [PW-1:0]    wr_ptr;
   logic [PW-1:0]    rd_ptr;
   logic [WIDTH-1:0] slot [DEPTH];

   // one register per entry, loaded only when the write pointer selects it
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (push && (wr_ptr == PW'(g))) begin
            q <= wr_data;
         end
      end
      assign slot[g] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) begin
            wr_ptr <= wr_ptr + 1'b1;
         end
         if (pop) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign rd_data = slot[rd_ptr];

endmodule

// File: rtl/rxf_flow.sv
module rxf_flow #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fifo_en,
   input  logic           wr_stb,
   input  logic           rd_stb,
   input  logic           stat_rd,
   input  logic [CW-1:0]  level,
   output rxf_pkg::flow_t flow,
   output logic           data_ready,
   output logic           overrun
);

   localparam logic [CW-1:0] FULL_CAP = CW'(DEPTH);
   localparam logic [CW-1:0] ONE_CAP  = CW'(1);

   logic [CW-1:0] cap;
   logic          nonempty;
   logic          has_room;

   assign cap      = fifo_en ? FULL_CAP : ONE_CAP;
   assign nonempty = (level != '0);
   assign has_room = (level < cap);

   always_comb begin
      flow.pop  = rd_stb && nonempty;
      // a same-cycle pop frees the slot the write needs
      flow.push = wr_stb && (has_room || flow.pop);
      flow.drop = wr_stb && !flow.push;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overrun <= 1'b0;
      end else if (flow.drop) begin
         overrun <= 1'b1;
      end else if (stat_rd) begin
         overrun <= 1'b0;
      end
   end

   assign data_ready = nonempty;

endmodule

// File: rtl/rxf_trigger.sv
module rxf_trigger #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned TRIG_0 = 8,
   parameter int unsigned TRIG_1 = 16,
   parameter int unsigned TRIG_2 = 56,
   parameter int unsigned TRIG_3 = 60,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          fifo_en,
   input  logic          irq_en,
   input  logic [1:0]    sel,
   input  logic [CW-1:0] level,
   output logic          irq,
   output logic [3:0]    isr_code
);

   localparam int unsigned NSEL = 4;

   logic [CW-1:0] thr_tab [NSEL];
   logic [CW-1:0] thr;
   logic          reached;

   for (genvar g = 0; g < NSEL; g++) begin : g_thr
      localparam int unsigned TV = (g == 0) ? TRIG_0 :
                                   (g == 1) ? TRIG_1 :
                                   (g == 2) ? TRIG_2 : TRIG_3;
      if (TV < 1 || TV > DEPTH) begin : g_bad
         $error("threshold %0d out of range 1..%0d", TV, DEPTH);
      end
      assign thr_tab[g] = CW'(TV);
   end

   // a single holding slot triggers on one character
   assign thr     = fifo_en ? thr_tab[sel] : CW'(1);
   assign reached = (level >= thr);
   assign irq     = irq_en && reached;

   always_comb begin
      if (irq) begin
         isr_code = rxf_pkg::ISR_RX_AVAIL;
      end else begin
         isr_code = rxf_pkg::ISR_NONE;
      end
   end

endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned TRIG_0 = 8,
   parameter int unsigned TRIG_1 = 16,
   parameter int unsigned TRIG_2 = 56,
   parameter int unsigned TRIG_3 = 60,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             rx_irq_en,
   input  logic [1:0]       trig_sel,
   input  logic             wr_stb,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_stb,
   input  logic             stat_rd,
   output logic [WIDTH-1:0] rd_data,
   output logic [CW-1:0]    fill_level,
   output logic             data_ready,
   output logic             rx_irq,
   output logic [3:0]       isr_code,
   output logic             overrun
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("WIDTH must be at least 1");
   end

   rxf_pkg::flow_t flow;

   rxf_flow #(
      .DEPTH (DEPTH)
   ) u_flow (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_en    (fifo_en),
      .wr_stb     (wr_stb),
      .rd_stb     (rd_stb),
      .stat_rd    (stat_rd),
      .level      (fill_level),
      .flow       (flow),
      .data_ready (data_ready),
      .overrun    (overrun)
   );

   rxf_store #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (flow.push),
      .pop     (flow.pop),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .level   (fill_level)
   );

   rxf_trigger #(
      .DEPTH  (DEPTH),
      .TRIG_0 (TRIG_0),
      .TRIG_1 (TRIG_1),
      .TRIG_2 (TRIG_2),
      .TRIG_3 (TRIG_3)
   ) u_trig (
      .fifo_en  (fifo_en),
      .irq_en   (rx_irq_en),
      .sel      (trig_sel),
      .level    (fill_level),
      .irq      (rx_irq),
      .isr_code (isr_code)
   );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned TRIG_0 = 8,
   parameter int unsigned TRIG_1 = 16,
   parameter int unsigned TRIG_2 = 56,
   parameter int unsigned TRIG_3 = 60,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fifo_en,
   input logic          rx_irq_en,
   input logic [1:0]    trig_sel,
   input logic          wr_stb,
   input logic          rd_stb,
   input logic [CW-1:0] fill_level,
   input logic          data_ready,
   input logic          rx_irq,
   input logic [3:0]    isr_code,
   input logic          overrun
);

   int unsigned limit;
   int unsigned room;

   always_comb begin
      case (trig_sel)
         2'd0:    limit = TRIG_0;
         2'd1:    limit = TRIG_1;
         2'd2:    limit = TRIG_2;
         default: limit = TRIG_3;
      endcase
      room = fifo_en ? DEPTH : 1;
   end

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fill_level) <= DEPTH);

   a_r2_ready_after_store: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && fill_level == '0) |=> data_ready);

   a_r4_level_vs_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && rx_irq_en) |-> (rx_irq == (int'(fill_level) >= limit)));

   a_r6_code_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
      isr_code == (rx_irq ? 4'b0100 : 4'b0001));

   a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_irq_en |-> !rx_irq);

   a_r9_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !rd_stb && int'(fill_level) >= room) |=> (overrun && $stable(fill_level)));

   a_r10_both_keep_level: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && rd_stb && fill_level != '0) |=> $stable(fill_level));

endmodule

bind rx_fifo_trig rxf_checker #(
   .DEPTH  (DEPTH),
   .TRIG_0 (TRIG_0),
   .TRIG_1 (TRIG_1),
   .TRIG_2 (TRIG_2),
   .TRIG_3 (TRIG_3)
) u_rxf_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .fifo_en    (fifo_en),
   .rx_irq_en  (rx_irq_en),
   .trig_sel   (trig_sel),
   .wr_stb     (wr_stb),
   .rd_stb     (rd_stb),
   .fill_level (fill_level),
   .data_ready (data_ready),
   .rx_irq     (rx_irq),
   .isr_code   (isr_code),
   .overrun    (overrun)
);

// File: tb/test_rx_fifo_trig.sv
module test_rx_fifo_trig;

   localparam int CLK_PERIOD = 10;
   localparam int CAP        = 64;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       fifo_en, rx_irq_en, wr_stb, rd_stb, stat_rd;
   logic [1:0] trig_sel;
   logic [7:0] wr_data, rd_data;
   logic [6:0] fill_level;
   logic       data_ready, rx_irq, overrun;
   logic [3:0] isr_code;

   int        n_chk  = 0;
   int        n_fail = 0;
   int        mdl_lvl = 0;
   bit        mdl_ovr = 0;
   logic [7:0] exp_q [$];
   logic [7:0] seq_byte = 8'h30;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rx_fifo_trig i_rx_fifo_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_en    (fifo_en),
      .rx_irq_en  (rx_irq_en),
      .trig_sel   (trig_sel),
      .wr_stb     (wr_stb),
      .wr_data    (wr_data),
      .rd_stb     (rd_stb),
      .stat_rd    (stat_rd),
      .rd_data    (rd_data),
      .fill_level (fill_level),
      .data_ready (data_ready),
      .rx_irq     (rx_irq),
      .isr_code   (isr_code),
      .overrun    (overrun)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int thr_of(input logic [1:0] s, input logic fe);
      if (!fe) return 1;
      case (s)
         2'd0: return 8;
         2'd1: return 16;
         2'd2: return 56;
         default: return 60;
      endcase
   endfunction

   // compare every visible output with the bench model
   task automatic chk_state(input string req);
      bit exp_irq;
      exp_irq = rx_irq_en && (mdl_lvl >= thr_of(trig_sel, fifo_en));
      chk(fill_level == 7'(mdl_lvl), req, "fill_level", fill_level, mdl_lvl);
      chk(data_ready == (mdl_lvl != 0), req, "data_ready", data_ready, int'(mdl_lvl != 0));
      chk(rx_irq == exp_irq, req, "rx_irq", rx_irq, exp_irq);
      chk(isr_code == (exp_irq ? 4'b0100 : 4'b0001), req, "isr_code", isr_code,
          exp_irq ? 4 : 1);
      chk(overrun == mdl_ovr, req, "overrun", overrun, mdl_ovr);
   endtask

   // driver + monitor: one clock cycle of stimulus, called at a falling edge
   task automatic step(input bit w, input bit r, input bit s);
      bit rok, wok;
      int cap;
      wr_stb  = w;
      wr_data = seq_byte;
      rd_stb  = r;
      stat_rd = s;
      cap = fifo_en ? CAP : 1;
      rok = r && (mdl_lvl > 0);
      wok = w && ((mdl_lvl < cap) || rok);
      if (rok) begin
         // monitor: head of the scoreboard must be on rd_data now (R3)
         chk(rd_data == exp_q[0], "R3", "rd_data order", rd_data, exp_q[0]);
         void'(exp_q.pop_front());
      end
      if (wok) begin
         exp_q.push_back(seq_byte);
      end
      if (s) mdl_ovr = 0;
      if (w && !wok) mdl_ovr = 1;
      mdl_lvl = mdl_lvl + int'(wok) - int'(rok);
      if (w) seq_byte = seq_byte + 8'd7;
      @(negedge clk);
      wr_stb  = 1'b0;
      rd_stb  = 1'b0;
      stat_rd = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0;
      fifo_en = 1'b1; rx_irq_en = 1'b1; trig_sel = 2'd0;
      wr_stb = 1'b0; rd_stb = 1'b0; stat_rd = 1'b0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_state("R1");

      // R2: first character sets data-ready
      step(1, 0, 0);
      chk_state("R2");

      // R4/R6: threshold 8 crossing
      for (int i = 0; i < 7; i++) begin
         step(1, 0, 0);
         chk_state("R4");
      end
      chk(rx_irq == 1'b1, "R4", "irq at 8", rx_irq, 1);
      chk(isr_code == 4'b0100, "R6", "isr at 8", isr_code, 4);

      // R5: one read drops below threshold at once
      step(0, 1, 0);
      chk(rx_irq == 1'b0, "R5", "irq below thr", rx_irq, 0);
      chk_state("R5");

      // R4: threshold 16, then select change to 56
      trig_sel = 2'd1;
      for (int i = 0; i < 9; i++) begin
         step(1, 0, 0);
         chk_state("R4");
      end
      trig_sel = 2'd2;
      #1;
      chk(rx_irq == 1'b0, "R4", "irq after sel 56", rx_irq, 0);
      chk_state("R4");

      // R7: masked interrupt, data-ready unaffected
      trig_sel = 2'd0;
      rx_irq_en = 1'b0;
      step(1, 0, 0);
      chk_state("R7");
      chk(isr_code == 4'b0001, "R7", "isr masked", isr_code, 1);
      rx_irq_en = 1'b1;

      // fill to capacity with threshold 60
      trig_sel = 2'd3;
      while (mdl_lvl < CAP) begin
         step(1, 0, 0);
         chk_state("R4");
      end

      // R9: overflow write dropped, flag sticky until status read
      step(1, 0, 0);
      chk_state("R9");
      step(0, 0, 0);
      chk(overrun == 1'b1, "R9", "overrun sticky", overrun, 1);
      step(0, 0, 1);
      chk_state("R9");
      step(1, 0, 1);
      chk(overrun == 1'b1, "R9", "set wins over clear", overrun, 1);
      step(0, 0, 1);
      chk_state("R9");

      // R10: write and read together at capacity
      step(1, 1, 0);
      chk_state("R10");
      step(1, 1, 0);
      chk_state("R10");

      // drain with order checks, R2 at empty
      while (mdl_lvl > 0) begin
         step(0, 1, 0);
         chk_state("R2");
      end
      step(0, 1, 0);
      chk_state("R10");

      // R8: single holding slot
      fifo_en = 1'b0;
      trig_sel = 2'd0;
      step(1, 0, 0);
      chk_state("R8");
      chk(rx_irq == 1'b1, "R8", "irq one char", rx_irq, 1);
      step(1, 0, 0);
      chk_state("R8");
      step(1, 1, 1);
      chk_state("R8");
      step(0, 1, 0);
      chk_state("R8");

      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule